// File: doc/BRIEF.md
# ADC sample to Q15 normalizer

This block takes one 16-bit converter sample per cycle and turns it into a signed Q1.15 fraction, which is the sample divided by full scale. In Q1.15 the top bit has weight -1 and the lower bits have weights 1/2 down to 1/32768. Two per-sample controls set how the sample is handled.

The first control states the converter's coding. The sample is either two's complement already, or it is offset (straight) binary. Offset binary is mapped to two's complement by flipping only the top bit.

The second control selects the scaling:

- **Divide by 32768.** No logic is needed. The bits pass through unchanged and only their weights are read differently.
- **Divide by 32767.** A cheap approximation is used in place of a divider. A sample with a magnitude of at least one half of full scale is moved one LSB further from zero. Smaller samples pass through unchanged. Two codes are handled as exceptions:
  - The positive full-scale code is never incremented, so it cannot wrap to the most negative code.
  - The most negative code is first clamped to -32767, so it has a representable magnitude.

The result is held in a single output register and is marked by an output valid one clock later.

Top module: `adc_q15_norm`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_q15` = 0.
- R2: `out_valid` is high in the cycle after a rising edge where `in_valid` was high, and low in the cycle after one where it was low.
- R3: When `in_valid` is low at an edge, `out_q15` keeps its previous value.
- R4: When `fmt_offset` = 1, the sample is treated as offset binary and bit 15 is inverted before scaling. When `fmt_offset` = 0, the sample is used as two's complement unchanged.
- R5: When `div_32767` = 0, `out_q15` equals the two's-complement sample bit for bit.
- R6: When `div_32767` = 1, a two's-complement sample whose magnitude is below 0x4000 is output unchanged.
- R7: When `div_32767` = 1, a positive sample in the range 0x4000 to 0x7FFE is output plus one.
- R8: When `div_32767` = 1, a negative sample in the range -0x4000 to -0x7FFF is output minus one. For example, 0xC000 gives 0xBFFF and 0x8001 gives 0x8000.
- R9: When `div_32767` = 1, the positive full-scale sample 0x7FFF is output as 0x7FFF.
- R10: When `div_32767` = 1, the sample 0x8000 is clamped to -32767 and then corrected, so the output is 0x8000.
- R11: `fmt_offset` and `div_32767` are sampled on the same edge as the data. A change of either control affects only the samples taken with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_offset | input | 1 | 1 = sample is offset binary, 0 = two's complement |
| div_32767 | input | 1 | 1 = divide-by-32767 approximation, 0 = divide by 32768 |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 16 | Raw converter sample |
| out_valid | output | 1 | Registered result present |
| out_q15 | output | 16 | Q1.15 result |

## Verification
The hardest situations to reach from the ports are the extreme codes and the exact correction boundaries under both codings:

- 0x7FFF and 0x8000, which arrive as 0xFFFF and 0x0000 in offset binary;
- ±0x4000 and the codes next to them.

Random samples hit any one of these codes with a chance of about 1 in 65536. For that reason, each of these codes is driven directly under every combination of the two controls. The controls are also toggled on every cycle while the sample stays fixed, which shows that they are taken on the same edge as the data. Long random runs then cover the mix of valid gaps, codings and modes.

// File: rtl/adc_q15_pkg.sv
package adc_q15_pkg;
  typedef enum logic {
    CODE_TWOS   = 1'b0,
    CODE_OFFSET = 1'b1
  } sample_code_e;

  typedef enum logic {
    SCALE_POW2  = 1'b0,
    SCALE_NEAR1 = 1'b1
  } scale_mode_e;
endpackage

// File: rtl/adc_fmt_align.sv
module adc_fmt_align #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  logic         code_sel,
  output logic [W-1:0] twos
);
  import adc_q15_pkg::*;

  always_comb begin
    twos = raw;
    if (sample_code_e'(code_sel) == CODE_OFFSET) begin
      twos[W-1] = ~raw[W-1];
    end
  end
endmodule

// File: rtl/q15_scale_adjust.sv
module q15_scale_adjust #(
  parameter int W = 16
) (
  input  logic [W-1:0] twos,
  input  logic         mode_sel,
  output logic [W-1:0] adj
);
  import adc_q15_pkg::*;

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] HALF_FS  = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] ONE_LSB  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] clamped;
  logic         is_neg;
  logic [W-1:0] mag;
  logic         big;
  logic         at_top;

  always_comb begin
    clamped = (twos == MOST_NEG) ? (MOST_NEG + ONE_LSB) : twos;
    is_neg  = clamped[W-1];
    mag     = is_neg ? (~clamped + ONE_LSB) : clamped;
    big     = (mag >= HALF_FS);
    at_top  = (clamped == MOST_POS);
  end

  always_comb begin
    if (scale_mode_e'(mode_sel) == SCALE_POW2) begin
      adj = twos;
    end else if (big && !at_top) begin
      adj = is_neg ? (clamped - ONE_LSB) : (clamped + ONE_LSB);
    end else begin
      adj = clamped;
    end
  end
endmodule

// File: rtl/q15_out_stage.sv
module q15_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) begin
        q <= d;
      end
    end
  end
endmodule

// File: rtl/adc_q15_norm.sv
module adc_q15_norm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fmt_offset,
  input  logic         div_32767,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  output logic         out_valid,
  output logic [W-1:0] out_q15
);
  logic [W-1:0] twos_w;
  logic [W-1:0] adj_w;

  adc_fmt_align #(.W(W)) u_align (
    .raw      (in_sample),
    .code_sel (fmt_offset),
    .twos     (twos_w)
  );

  q15_scale_adjust #(.W(W)) u_adjust (
    .twos     (twos_w),
    .mode_sel (div_32767),
    .adj      (adj_w)
  );

  q15_out_stage #(.W(W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       (adj_w),
    .q_valid (out_valid),
    .q       (out_q15)
  );
endmodule

// File: rtl/adc_q15_norm_chk.sv
module adc_q15_norm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         fmt_offset,
  input logic         div_32767,
  input logic         in_valid,
  input logic [W-1:0] in_sample,
  input logic         out_valid,
  input logic [W-1:0] out_q15
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_q15 == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_q15));

  // R5
  pow2_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !div_32767 && !fmt_offset) |=> out_q15 == $past(in_sample));

  // R9
  full_scale_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && div_32767 &&
     in_sample == {fmt_offset, {(W-1){1'b1}}}) |=> out_q15 == {1'b0, {(W-1){1'b1}}});

  // R8
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && div_32767) |=> out_q15[W-1] == $past(in_sample[W-1] ^ fmt_offset));
endmodule

bind adc_q15_norm adc_q15_norm_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fmt_offset (fmt_offset),
  .div_32767  (div_32767),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .out_valid  (out_valid),
  .out_q15    (out_q15)
);

// File: tb/adc_q15_norm_tb.sv
`timescale 1ns/1ps
module adc_q15_norm_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_offset = 1'b0;
  logic        div_32767 = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        out_valid;
  logic [15:0] out_q15;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  logic [15:0] last_out = '0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  adc_q15_norm #(.W(16)) u_dut (
    .clk(clk), .rst(rst), .fmt_offset(fmt_offset), .div_32767(div_32767),
    .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_q15(out_q15)
  );

  function automatic logic [15:0] expect_q15(logic [15:0] s, logic off, logic near);
    int t;
    int r;
    t = off ? (int'(s) - 32768) : int'($signed(s));
    if (!near) return 16'(t);
    if (t == -32768) t = -32767;
    r = t;
    if (t >= 16384 && t != 32767) r = t + 1;
    else if (t <= -16384) r = t - 1;
    return 16'(r);
  endfunction

  function automatic string req_of(logic [15:0] s, logic off, logic near);
    int t;
    t = off ? (int'(s) - 32768) : int'($signed(s));
    if (off && !near) return "R4/R5";
    if (!near) return "R5";
    if (t == -32768) return "R10";
    if (t == 32767) return "R9";
    if (t >= 16384) return "R7";
    if (t <= -16384) return "R8";
    return "R6";
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [15:0] s, logic off, logic near);
    logic [15:0] e;
    in_valid = v; in_sample = s; fmt_offset = off; div_32767 = near;
    @(negedge clk);
    check("R2", {15'd0, out_valid}, {15'd0, v});
    if (v) begin
      e = expect_q15(s, off, near);
      check(req_of(s, off, near), out_q15, e);
      last_out = e;
    end else begin
      check("R3", out_q15, last_out);
    end
  endtask

  initial begin
    logic [15:0] corners [12];
    corners = '{16'h7FFF, 16'h8000, 16'h8001, 16'h4000, 16'h3FFF, 16'hC000,
                16'hC001, 16'hBFFF, 16'h0000, 16'hFFFF, 16'h7FFE, 16'h4001};
    void'($urandom(32'd20240601));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {out_valid, out_q15}, 17'd0);

    rst = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 12; i++) begin
        step(1'b1, corners[i], m[0], m[1]);
      end
    end
    // R4 offset coding of extremes
    step(1'b1, 16'hFFFF, 1'b1, 1'b1);
    step(1'b1, 16'h0000, 1'b1, 1'b1);
    step(1'b1, 16'h0000, 1'b1, 1'b0);
    // R3 idle cycles with garbage data
    step(1'b0, 16'h1234, 1'b1, 1'b1);
    step(1'b0, 16'h7FFF, 1'b0, 1'b0);
    // R11 controls toggle each cycle with the data fixed
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 16'h5555, i[0], i[1]);
    end
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 16'hC000, i[1], i[0]);
    end

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, 16'($urandom), 1'($urandom), 1'($urandom));
    end

    // R1 reset mid-stream
    in_valid = 1'b1; in_sample = 16'h4444; rst = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, out_q15}, 17'd0);
    rst = 1'b0; in_valid = 1'b0;
    last_out = '0;
    step(1'b0, 16'h0F0F, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule